// File: doc/BRIEF.md
# BCD Latched Display Scanner

The scanner feeds a row of seven-segment digits where every digit carries its own BCD latch and decoder. The scanner does not produce segment patterns. It places one BCD nibble at a time on a shared 4-bit bus and pulses the latch strobe of the digit that nibble belongs to. Each latch then holds its digit until the next pass refreshes it. Digit 0 goes out first and digit 3 last. The sequence repeats for as long as enable is held high. A single-clock done pulse marks the end of every complete pass.

A dual-group mode drives a second bank of displays from a second 16-bit word. Its nibbles appear on a second bus at the same moment as the first bank's nibbles, so both banks share the four strobes. A 2-bit polarity input can flip the data buses, the strobes, or both, to suit sinking or sourcing output stages. An external tick paces the scan. Each digit occupies four ticks: the nibble is held for all four, and the strobe is active only in the middle two, so the data is settled at both strobe edges.

Top module: `bcd_latch_scan`

## Requirements
- R1: While `en_i` is high, `data_a_o` presents nibble k of the captured first word (bits 4k+3..4k) for digit k. The digits go out in the order 0, 1, 2, 3, and each digit occupies four accepted ticks.
- R2: Only strobe k can be active while digit k is on the bus. It is active only in the second and third tick slot of that digit, and inactive in the first and fourth.
- R3: When dual mode (`dual_i` = 1) is captured, `data_b_o` carries nibble k of the second word during digit k, in the same cycles as `data_a_o`.
- R4: When single mode (`dual_i` = 0) is captured, `data_b_o` stays at its inactive level for the whole pass.
- R5: After digit 3 the scan wraps to digit 0 and continues without a gap while `en_i` stays high.
- R6: `done_o` is high for exactly one clock cycle, the cycle after the edge that takes the last tick of digit 3. It is low at all other times.
- R7: `pol_i[0]` = 1 inverts both data buses, including their inactive level of 0. `pol_i[1]` = 1 inverts the strobes, so their inactive level becomes 1. When `pol_i` = 0, all outputs are active-high.
- R8: When `en_i` falls, all strobes go inactive in the same cycle. On the next edge the scan returns to idle: data buses go inactive and the digit position resets. The next enable starts over at digit 0.
- R9: Both words and the mode are captured on the first enabled edge and again at each wrap. A change on the inputs during a pass does not affect that pass.
- R10: During and after reset, the data buses and strobes sit at their inactive levels and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Scan enable |
| dual_i | input | 1 | 1 = two display groups, 0 = one group |
| pol_i | input | 2 | Bit 0 inverts data buses, bit 1 inverts strobes |
| tick_i | input | 1 | Step pacing pulse, one clock wide |
| word_a_i | input | 16 | BCD word for first group |
| word_b_i | input | 16 | BCD word for second group |
| data_a_o | output | 4 | First group nibble bus |
| data_b_o | output | 4 | Second group nibble bus |
| strobe_o | output | 4 | Per-digit latch strobes |
| done_o | output | 1 | One-cycle pass-complete pulse |

## Verification
The hardest case to reach is an enable drop while a strobe is active in the middle of a pass. The same goes for a word that changes partway through a pass, because the result only shows up several digits later. The bench ticks a pass up to a strobe-active slot of digit 2 and drops enable there, then checks that the strobes clear in that same cycle. It then re-enables and confirms that the bus restarts at digit 0. For input changes during a pass, it alters the word just after capture and follows every remaining digit to confirm the old value persists. The new value must appear only after the wrap.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int unsigned DIGITS_DEF    = 4;
  localparam int unsigned NIB_W_DEF     = 4;
  localparam int unsigned SUB_TICKS_DEF = 4;
  localparam int unsigned STB_FIRST_DEF = 1;
  localparam int unsigned STB_LAST_DEF  = 2;
  localparam int unsigned GROUPS        = 2;
endpackage

// File: rtl/bls_seq.sv
module bls_seq #(
  parameter int unsigned DIGITS    = 4,
  parameter int unsigned SUB_TICKS = 4,
  localparam int unsigned DIG_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int unsigned SUB_W = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic [DIG_W-1:0] dig_o,
  output logic [SUB_W-1:0] sub_o,
  output logic             load_o,
  output logic             done_o
);
  localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(DIGITS - 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_TICKS - 1);

  logic             active_q, done_q;
  logic [DIG_W-1:0] dig_q;
  logic [SUB_W-1:0] sub_q;
  logic             wrap;

  assign wrap   = active_q && tick_i && (sub_q == SUB_LAST) && (dig_q == DIG_LAST);
  assign load_o = en_i && (!active_q || wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      dig_q    <= '0;
      sub_q    <= '0;
      done_q   <= 1'b0;
    end else if (!en_i) begin
      active_q <= 1'b0;
      dig_q    <= '0;
      sub_q    <= '0;
      done_q   <= 1'b0;
    end else if (!active_q) begin
      active_q <= 1'b1;
      dig_q    <= '0;
      sub_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= wrap;
      if (tick_i) begin
        if (sub_q == SUB_LAST) begin
          sub_q <= '0;
          dig_q <= (dig_q == DIG_LAST) ? '0 : dig_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign dig_o    = dig_q;
  assign sub_o    = sub_q;
  assign done_o   = done_q;

  // R6
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R8
  idle_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!active_q && dig_q == '0 && sub_q == '0));
  // R1
  sub_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_q && tick_i && sub_q != SUB_LAST) |=> (sub_q == $past(sub_q) + 1'b1));
  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wrap) |=> (active_q && dig_q == '0 && sub_q == '0));
endmodule

// File: rtl/bls_capture.sv
module bls_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              active_i,
  input  logic              dual_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic              dual_o,
  output logic [WORD_W-1:0] word_a_o,
  output logic [WORD_W-1:0] word_b_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dual_o   <= 1'b0;
      word_a_o <= '0;
      word_b_o <= '0;
    end else if (load_i) begin
      dual_o   <= dual_i;
      word_a_o <= word_a_i;
      word_b_o <= word_b_i;
    end
  end

  // R9
  hold_words_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !load_i) |=> ($stable(word_a_o) && $stable(word_b_o) && $stable(dual_o)));
endmodule

// File: rtl/bls_nib_sel.sv
module bls_nib_sel #(
  parameter int unsigned DIGITS = 4,
  parameter int unsigned NIB_W  = 4,
  localparam int unsigned WORD_W = DIGITS * NIB_W,
  localparam int unsigned DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [DIG_W-1:0]  dig_i,
  input  logic              en_i,
  output logic [NIB_W-1:0]  nib_o
);
  always_comb begin
    nib_o = '0;
    if (en_i) begin
      for (int k = 0; k < DIGITS; k++) begin
        if (dig_i == DIG_W'(k)) nib_o = word_i[k*NIB_W +: NIB_W];
      end
    end
  end
endmodule

// File: rtl/bcd_latch_scan.sv
module bcd_latch_scan
  import bls_pkg::*;
#(
  parameter int unsigned DIGITS    = DIGITS_DEF,
  parameter int unsigned NIB_W     = NIB_W_DEF,
  parameter int unsigned SUB_TICKS = SUB_TICKS_DEF,
  parameter int unsigned STB_FIRST = STB_FIRST_DEF,
  parameter int unsigned STB_LAST  = STB_LAST_DEF,
  localparam int unsigned WORD_W = DIGITS * NIB_W,
  localparam int unsigned DIG_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int unsigned SUB_W  = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              dual_i,
  input  logic [1:0]        pol_i,
  input  logic              tick_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  output logic [NIB_W-1:0]  data_a_o,
  output logic [NIB_W-1:0]  data_b_o,
  output logic [DIGITS-1:0] strobe_o,
  output logic              done_o
);
  logic             active, load, dual_q;
  logic [DIG_W-1:0] dig;
  logic [SUB_W-1:0] sub;
  logic [WORD_W-1:0] word_q [GROUPS];
  logic [NIB_W-1:0]  nib    [GROUPS];
  logic [GROUPS-1:0] grp_en;
  logic [DIGITS-1:0] stb_raw;
  logic              stb_win;

  bls_seq #(.DIGITS(DIGITS), .SUB_TICKS(SUB_TICKS)) i_seq (
    .clk_i, .rst_ni, .en_i, .tick_i,
    .active_o(active), .dig_o(dig), .sub_o(sub), .load_o(load), .done_o(done_o)
  );

  bls_capture #(.WORD_W(WORD_W)) i_cap (
    .clk_i, .rst_ni,
    .load_i(load), .active_i(active), .dual_i, .word_a_i, .word_b_i,
    .dual_o(dual_q), .word_a_o(word_q[0]), .word_b_o(word_q[1])
  );

  assign grp_en[0] = active;
  assign grp_en[1] = active && dual_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    bls_nib_sel #(.DIGITS(DIGITS), .NIB_W(NIB_W)) i_sel (
      .word_i(word_q[g]), .dig_i(dig), .en_i(grp_en[g]), .nib_o(nib[g])
    );
  end

  // strobe only inside the middle slots of a step, cut at once on enable loss
  assign stb_win = active && en_i &&
                   (sub >= SUB_W'(STB_FIRST)) && (sub <= SUB_W'(STB_LAST));

  for (genvar k = 0; k < DIGITS; k++) begin : g_stb
    assign stb_raw[k] = stb_win && (dig == DIG_W'(k));
  end

  assign data_a_o = nib[0] ^ {NIB_W{pol_i[0]}};
  assign data_b_o = nib[1] ^ {NIB_W{pol_i[0]}};
  assign strobe_o = stb_raw ^ {DIGITS{pol_i[1]}};

  // R2
  stb_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o ^ {DIGITS{pol_i[1]}}));
  // R8
  stb_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (strobe_o == {DIGITS{pol_i[1]}}));
  // R4
  single_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dual_q |-> (data_b_o == {NIB_W{pol_i[0]}}));
endmodule

// File: tb/test_bcd_latch_scan.sv
module test_bcd_latch_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, dual = 1'b0, tick = 1'b0;
  logic [1:0]  pol = 2'd0;
  logic [15:0] wa = '0, wb = '0;
  logic [3:0]  da, db, stb;
  logic        done;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  bcd_latch_scan i_bcd_latch_scan (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dual_i(dual), .pol_i(pol),
    .tick_i(tick), .word_a_i(wa), .word_b_i(wb),
    .data_a_o(da), .data_b_o(db), .strobe_o(stb), .done_o(done)
  );

  // {dual, pol, word_a, word_b}
  localparam logic [34:0] VEC [6] = '{
    {1'b0, 2'd0, 16'h1234, 16'h0000},
    {1'b1, 2'd0, 16'h5678, 16'h9012},
    {1'b0, 2'd1, 16'h0987, 16'h4321},
    {1'b1, 2'd2, 16'h4455, 16'h6677},
    {1'b1, 2'd3, 16'h9900, 16'h1357},
    {1'b0, 2'd3, 16'h2468, 16'hFFFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] nib(input logic [15:0] w, input int d);
    return w[d*4 +: 4];
  endfunction

  task automatic clk1();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic do_tick();
    tick = 1'b1; @(posedge clk); @(negedge clk); tick = 1'b0; #1;
  endtask

  // checks one full pass starting at digit 0 slot 0
  task automatic walk_pass(input logic [15:0] a, input logic [15:0] b, input logic d,
                           input logic [1:0] p);
    for (int dg = 0; dg < 4; dg++) begin
      for (int s = 0; s < 4; s++) begin
        logic [3:0] e_stb;
        e_stb = ((s == 1 || s == 2) ? (4'b0001 << dg) : 4'b0000) ^ {4{p[1]}};
        chk("R1 data_a", 32'(da), 32'(nib(a, dg) ^ {4{p[0]}}));
        if (d) chk("R3 data_b", 32'(db), 32'(nib(b, dg) ^ {4{p[0]}}));
        else   chk("R4 data_b idle", 32'(db), 32'({4{p[0]}}));
        chk("R2 R7 strobe", 32'(stb), 32'(e_stb));
        chk("R6 done low mid-pass", 32'(done), 32'(0));
        do_tick();
      end
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    // R10 reset
    chk("R10 data_a", 32'(da), 32'(0));
    chk("R10 data_b", 32'(db), 32'(0));
    chk("R10 strobe", 32'(stb), 32'(0));
    chk("R10 done", 32'(done), 32'(0));
    @(negedge clk); rst_n = 1'b1; #1;
    clk1();
    chk("R6 done idle", 32'(done), 32'(0));

    for (int v = 0; v < 6; v++) begin
      en = 1'b0;
      {dual, pol, wa, wb} = VEC[v];
      clk1();
      chk("R7 idle data_a", 32'(da), 32'({4{pol[0]}}));
      chk("R7 idle strobe", 32'(stb), 32'({4{pol[1]}}));
      en = 1'b1;
      clk1();
      walk_pass(VEC[v][31:16], VEC[v][15:0], VEC[v][34], VEC[v][33:32]);
      chk("R6 done pulse", 32'(done), 32'(1));
      chk("R5 wrap digit0", 32'(da), 32'(nib(VEC[v][31:16], 0) ^ {4{pol[0]}}));
      clk1();
      chk("R6 done one cycle", 32'(done), 32'(0));
      walk_pass(VEC[v][31:16], VEC[v][15:0], VEC[v][34], VEC[v][33:32]);
      chk("R5 second pass done", 32'(done), 32'(1));
    end

    // R8 enable drop during active strobe
    en = 1'b0; pol = 2'd0; dual = 1'b0; wa = 16'h3141; wb = 16'h0;
    clk1();
    en = 1'b1; clk1();
    for (int i = 0; i < 9; i++) do_tick();
    chk("R8 strobe before drop", 32'(stb), 32'(4'b0100));
    en = 1'b0; #1;
    chk("R8 strobe same cycle", 32'(stb), 32'(0));
    clk1();
    chk("R8 data idle", 32'(da), 32'(0));
    do_tick();
    chk("R8 ticks ignored idle", 32'(da), 32'(0));
    chk("R6 no done idle", 32'(done), 32'(0));
    en = 1'b1; clk1();
    chk("R8 restart digit0", 32'(da), 32'(4'h1));
    chk("R8 restart strobe off", 32'(stb), 32'(0));
    do_tick();
    chk("R8 restart strobe0", 32'(stb), 32'(4'b0001));

    // R9 input change mid-pass
    en = 1'b0; clk1();
    wa = 16'h4321; wb = 16'h8888; dual = 1'b0;
    en = 1'b1; clk1();
    wa = 16'h8765; dual = 1'b1;
    walk_pass(16'h4321, 16'h8888, 1'b0, 2'd0);
    chk("R9 new word after wrap", 32'(da), 32'(4'h5));
    chk("R9 new mode after wrap", 32'(db), 32'(4'h8));
    en = 1'b0; clk1();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule